// File: doc/BRIEF.md
# DCF Medium-Access Timing Controller

This block handles the timing for a wireless MAC that uses the distributed coordination function. Software programs the interval lengths in microseconds. It also decides when to arm a backoff, how many slots it holds, and whether a received frame should be answered. The block does the cycle-accurate part. It turns the clock into microsecond ticks and keeps a virtual carrier-sense (NAV) counter loaded from the duration field of good receptions. It merges that counter with the physical carrier-sense input into a single medium-busy view.

On top of the medium-busy view the block runs three sequences:
- A deferred-transmission sequence. After the medium has stayed idle for a DIFS interval, the backoff slots count down. Any busy medium freezes the count and forces a fresh DIFS. When the count is exhausted the block emits a release pulse.
- A response sequence. It starts a software-prepared reply one SIFS after a good reception.
- A response-timeout sequence. It is armed by the end of a unicast transmission and cancelled by a good reception.

All inputs and outputs are plain level or single-cycle pulse signals. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure. Every event output is a one-cycle pulse that software or a neighbouring sequencer must capture when it occurs.

Top module: `dcf_mac_timing`

## Requirements
- R1: One microsecond lasts `cfg_cyc_per_us` clock cycles, with a value of 0 treated as 1. Every timer length (SIFS, DIFS, slot, timeout) is counted in these microsecond ticks. With a divider of N, an interval of T microseconds ends between T*N-(N-1) and T*N cycles after the edge that started it.
- R2: When a reception ends with a good FCS, the NAV takes the frame's duration value only if that value exceeds the NAV's current remaining count. The NAV decrements by one per microsecond tick. With duration D loaded at edge E and a divider of 1, the NAV is nonzero after edges E through E+D-1 and zero after edge E+D.
- R3: `medium_busy` is high whenever `phy_cs` is high or the NAV is nonzero. It follows `phy_cs` in the same cycle.
- R4: A `bo_start` pulse loads `bo_slots` and begins a DIFS wait. With the medium idle and a divider of 1, `tx_release` pulses once, DIFS + slots*slot cycles after the edge that sampled `bo_start`. A slot count of 0 releases right after the DIFS.
- R5: Any cycle with the medium busy during the DIFS wait or the slot countdown freezes the remaining slot count and discards the partial slot. Counting resumes only after a fresh full DIFS of idle medium. The release then comes DIFS + remaining*slot cycles after the last busy edge.
- R6: A good-FCS reception with `resp_en` high schedules a reply. If `resp_ready` is high at the edge where the SIFS expires, `tx_resp_start` pulses in the cycle SIFS after the reception edge. `resp_ready` may rise at any point before that expiry.
- R7: If `resp_ready` is low when the scheduled SIFS expires, no reply is started and `resp_missed` pulses in that cycle instead.
- R8: A `tx_done` pulse with `tx_unicast` high starts the response timeout. If the timeout is not cancelled, `timeout_evt` pulses in the cycle that comes timeout microseconds after that edge. A `tx_done` with `tx_unicast` low starts nothing.
- R9: A good-FCS reception while the timeout runs cancels it and pulses `resp_rcvd` in the following cycle. This holds even when the reception lands on the very edge where the timeout would have expired; in that case `timeout_evt` does not pulse.
- R10: During reset every output is low.
- R11: A reception ending with a bad FCS does not load the NAV, does not schedule a reply and does not cancel a running timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cyc_per_us | input | 8 | Clock cycles per microsecond |
| cfg_sifs_us | input | 16 | SIFS length in microseconds |
| cfg_difs_us | input | 16 | DIFS length in microseconds |
| cfg_slot_us | input | 16 | Backoff slot length in microseconds |
| cfg_timeout_us | input | 16 | Response timeout length in microseconds |
| phy_cs | input | 1 | Physical carrier sense, high while the medium is busy |
| rx_end | input | 1 | Pulse: a reception has ended |
| rx_fcs_ok | input | 1 | FCS status qualifying `rx_end` |
| rx_dur | input | 16 | Duration field of the ended reception, in microseconds |
| tx_done | input | 1 | Pulse: a transmission has finished |
| tx_unicast | input | 1 | Qualifies `tx_done` as a unicast frame awaiting a reply |
| resp_en | input | 1 | Software allows automatic replies to good receptions |
| resp_ready | input | 1 | Software has the reply frame prepared |
| bo_start | input | 1 | Pulse: arm a deferred transmission with `bo_slots` |
| bo_slots | input | 10 | Backoff slot count |
| medium_busy | output | 1 | Combined physical and virtual carrier sense |
| tx_resp_start | output | 1 | Pulse: start the prepared reply |
| tx_release | output | 1 | Pulse: deferred transmission may start |
| resp_missed | output | 1 | Pulse: reply skipped because the frame was not ready |
| timeout_evt | output | 1 | Pulse: response timeout expired |
| resp_rcvd | output | 1 | Pulse: good reception cancelled a running timeout |

## Verification
The timeout expiry and a cancelling good reception can fall on the same edge. The bench arms the timeout with a unicast `tx_done` and times the good reception so that it is sampled exactly on the expiry edge. The scoreboard then demands a single `resp_rcvd` in that cycle and treats any `timeout_evt` as an unexpected event. A second collision, a NAV load landing in the middle of a running DIFS wait, is provoked so that the release time shows whether the busy edges restarted the DIFS.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic [1:0] {
    BO_OFF  = 2'd0,
    BO_DIFS = 2'd1,
    BO_SLOT = 2'd2
  } bo_state_t;
endpackage

// File: rtl/dcf_us_tick.sv
module dcf_us_tick #(
  parameter int CYC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CYC_W-1:0] cfg_cyc_per_us,
  output logic             us_tick
);
  logic [CYC_W-1:0] cnt;
  logic [CYC_W-1:0] lim;

  assign lim     = (cfg_cyc_per_us == '0) ? '0 : cfg_cyc_per_us - 1'b1;
  assign us_tick = (cnt >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (us_tick) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dcf_nav.sv
module dcf_nav #(
  parameter int NAV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             us_tick,
  input  logic             load,
  input  logic [NAV_W-1:0] dur,
  output logic             nav_busy
);
  logic [NAV_W-1:0] nav;

  assign nav_busy = (nav != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                    nav <= '0;
    else if (load && (dur > nav))  nav <= dur;
    else if (us_tick && nav_busy)  nav <= nav - 1'b1;
  end
endmodule

// File: rtl/dcf_backoff.sv
module dcf_backoff
  import dcf_pkg::*;
#(
  parameter int US_W   = 16,
  parameter int SLOT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic              medium_busy,
  input  logic              bo_start,
  input  logic [SLOT_W-1:0] bo_slots,
  input  logic [US_W-1:0]   cfg_difs_us,
  input  logic [US_W-1:0]   cfg_slot_us,
  output logic              tx_release
);
  bo_state_t         st;
  logic [US_W-1:0]   difs_cnt;
  logic [US_W-1:0]   slot_cnt;
  logic [SLOT_W-1:0] slots_left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= BO_OFF;
      difs_cnt   <= '0;
      slot_cnt   <= '0;
      slots_left <= '0;
      tx_release <= 1'b0;
    end else begin
      tx_release <= 1'b0;
      if (bo_start) begin
        st         <= BO_DIFS;
        difs_cnt   <= cfg_difs_us;
        slots_left <= bo_slots;
      end else begin
        case (st)
          BO_DIFS: begin
            if (medium_busy) begin
              difs_cnt <= cfg_difs_us;
            end else if (us_tick) begin
              if (difs_cnt > 1) begin
                difs_cnt <= difs_cnt - 1'b1;
              end else if (slots_left == '0) begin
                tx_release <= 1'b1;
                st         <= BO_OFF;
              end else begin
                st       <= BO_SLOT;
                slot_cnt <= cfg_slot_us;
              end
            end
          end
          BO_SLOT: begin
            if (medium_busy) begin
              st       <= BO_DIFS;
              difs_cnt <= cfg_difs_us;
            end else if (us_tick) begin
              if (slot_cnt > 1) begin
                slot_cnt <= slot_cnt - 1'b1;
              end else if (slots_left <= 1) begin
                slots_left <= '0;
                tx_release <= 1'b1;
                st         <= BO_OFF;
              end else begin
                slots_left <= slots_left - 1'b1;
                slot_cnt   <= cfg_slot_us;
              end
            end
          end
          default: st <= BO_OFF;
        endcase
      end
    end
  end
endmodule

// File: rtl/dcf_resp.sv
module dcf_resp #(
  parameter int US_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            us_tick,
  input  logic            rx_good,
  input  logic            resp_en,
  input  logic            resp_ready,
  input  logic            ucast_done,
  input  logic [US_W-1:0] cfg_sifs_us,
  input  logic [US_W-1:0] cfg_timeout_us,
  output logic            tx_resp_start,
  output logic            resp_missed,
  output logic            timeout_evt,
  output logic            resp_rcvd
);
  logic            sifs_act;
  logic [US_W-1:0] sifs_cnt;
  logic            to_act;
  logic [US_W-1:0] to_cnt;

  // reply scheduling one SIFS after a good reception
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sifs_act      <= 1'b0;
      sifs_cnt      <= '0;
      tx_resp_start <= 1'b0;
      resp_missed   <= 1'b0;
    end else begin
      tx_resp_start <= 1'b0;
      resp_missed   <= 1'b0;
      if (rx_good && resp_en) begin
        sifs_act <= 1'b1;
        sifs_cnt <= cfg_sifs_us;
      end else if (sifs_act && us_tick) begin
        if (sifs_cnt > 1) begin
          sifs_cnt <= sifs_cnt - 1'b1;
        end else begin
          sifs_act <= 1'b0;
          if (resp_ready) tx_resp_start <= 1'b1;
          else            resp_missed   <= 1'b1;
        end
      end
    end
  end

  // response timeout after a unicast transmission
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      to_act      <= 1'b0;
      to_cnt      <= '0;
      timeout_evt <= 1'b0;
      resp_rcvd   <= 1'b0;
    end else begin
      timeout_evt <= 1'b0;
      resp_rcvd   <= 1'b0;
      if (rx_good && to_act) begin
        to_act    <= 1'b0;
        resp_rcvd <= 1'b1;
      end else if (ucast_done) begin
        to_act <= 1'b1;
        to_cnt <= cfg_timeout_us;
      end else if (to_act && us_tick) begin
        if (to_cnt > 1) begin
          to_cnt <= to_cnt - 1'b1;
        end else begin
          to_act      <= 1'b0;
          timeout_evt <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dcf_mac_timing.sv
module dcf_mac_timing #(
  parameter int CYC_W  = 8,
  parameter int US_W   = 16,
  parameter int SLOT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CYC_W-1:0]  cfg_cyc_per_us,
  input  logic [US_W-1:0]   cfg_sifs_us,
  input  logic [US_W-1:0]   cfg_difs_us,
  input  logic [US_W-1:0]   cfg_slot_us,
  input  logic [US_W-1:0]   cfg_timeout_us,
  input  logic              phy_cs,
  input  logic              rx_end,
  input  logic              rx_fcs_ok,
  input  logic [US_W-1:0]   rx_dur,
  input  logic              tx_done,
  input  logic              tx_unicast,
  input  logic              resp_en,
  input  logic              resp_ready,
  input  logic              bo_start,
  input  logic [SLOT_W-1:0] bo_slots,
  output logic              medium_busy,
  output logic              tx_resp_start,
  output logic              tx_release,
  output logic              resp_missed,
  output logic              timeout_evt,
  output logic              resp_rcvd
);
  logic us_tick;
  logic nav_busy;
  logic rx_good;
  logic ucast_done;

  assign rx_good     = rx_end & rx_fcs_ok;
  assign ucast_done  = tx_done & tx_unicast;
  assign medium_busy = phy_cs | nav_busy;

  dcf_us_tick #(.CYC_W(CYC_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .cfg_cyc_per_us(cfg_cyc_per_us), .us_tick(us_tick)
  );

  dcf_nav #(.NAV_W(US_W)) u_nav (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .load(rx_good),
    .dur(rx_dur), .nav_busy(nav_busy)
  );

  dcf_backoff #(.US_W(US_W), .SLOT_W(SLOT_W)) u_bo (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .medium_busy(medium_busy),
    .bo_start(bo_start), .bo_slots(bo_slots), .cfg_difs_us(cfg_difs_us),
    .cfg_slot_us(cfg_slot_us), .tx_release(tx_release)
  );

  dcf_resp #(.US_W(US_W)) u_resp (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .rx_good(rx_good),
    .resp_en(resp_en), .resp_ready(resp_ready), .ucast_done(ucast_done),
    .cfg_sifs_us(cfg_sifs_us), .cfg_timeout_us(cfg_timeout_us),
    .tx_resp_start(tx_resp_start), .resp_missed(resp_missed),
    .timeout_evt(timeout_evt), .resp_rcvd(resp_rcvd)
  );
endmodule

// File: rtl/dcf_mac_timing_chk.sv
module dcf_mac_timing_chk #(
  parameter int US_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rx_end,
  input logic            rx_fcs_ok,
  input logic [US_W-1:0] rx_dur,
  input logic            resp_ready,
  input logic            medium_busy,
  input logic            tx_resp_start,
  input logic            tx_release,
  input logic            resp_rcvd
);
  AST_RELEASE_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_release |-> $past(!medium_busy)); // R5

  AST_NAV_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_end && rx_fcs_ok && (rx_dur != '0)) |=> medium_busy); // R2

  AST_RCVD_NEEDS_GOOD_RX: assert property (@(posedge clk) disable iff (!rst_n)
    resp_rcvd |-> $past(rx_end && rx_fcs_ok)); // R9

  AST_REPLY_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_resp_start |-> $past(resp_ready)); // R6
endmodule

bind dcf_mac_timing dcf_mac_timing_chk #(.US_W(US_W)) u_chk (.*);

// File: tb/dcf_mac_timing_test.sv
module dcf_mac_timing_test;
  localparam int CLK_PERIOD = 10;
  localparam int SIFS = 3, DIFS = 5, SLOT = 4, TMO = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_cyc_per_us = 8'd1;
  logic [15:0] cfg_sifs_us = 16'(SIFS);
  logic [15:0] cfg_difs_us = 16'(DIFS);
  logic [15:0] cfg_slot_us = 16'(SLOT);
  logic [15:0] cfg_timeout_us = 16'(TMO);
  logic        phy_cs = 0, rx_end = 0, rx_fcs_ok = 0;
  logic [15:0] rx_dur = '0;
  logic        tx_done = 0, tx_unicast = 0, resp_en = 0, resp_ready = 0, bo_start = 0;
  logic [9:0]  bo_slots = '0;
  logic        medium_busy, tx_resp_start, tx_release, resp_missed, timeout_evt, resp_rcvd;

  dcf_mac_timing uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  typedef struct { int at; int tol; int kind; string req; } exp_t;
  exp_t sb[$];
  string kname [5] = '{"tx_resp_start", "resp_missed", "tx_release", "timeout_evt", "resp_rcvd"};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic expect_ev(input int at, input int tol, input int kind, input string req);
    exp_t e;
    e.at = at; e.tol = tol; e.kind = kind; e.req = req;
    sb.push_back(e);
  endtask

  // monitor: match every event pulse against the scoreboard
  always @(negedge clk) begin
    logic [4:0] ev;
    int hit;
    if (rst_n && !finished) begin
      ev = {resp_rcvd, timeout_evt, tx_release, resp_missed, tx_resp_start};
      for (int k = 0; k < 5; k++) begin
        if (ev[k]) begin
          hit = -1;
          for (int i = 0; i < sb.size(); i++)
            if (hit < 0 && sb[i].kind == k && cyc >= sb[i].at - sb[i].tol && cyc <= sb[i].at)
              hit = i;
          n_chk++;
          if (hit >= 0) sb.delete(hit);
          else begin
            n_fail++;
            $display("FAIL unexpected %s: actual cycle %0d expected none", kname[k], cyc);
          end
        end
      end
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].at < cyc) begin
          n_chk++; n_fail++;
          $display("FAIL %s missing %s: actual none expected cycle %0d", sb[i].req, kname[sb[i].kind], sb[i].at);
          sb.delete(i);
        end
      end
    end
  end

  task automatic step(); @(negedge clk); endtask
  task automatic wait_until(input int t); while (cyc < t) step(); endtask

  task automatic pulse_rx(input int dur, input bit ok, output int e);
    step();
    rx_end = 1; rx_fcs_ok = ok; rx_dur = 16'(dur); e = cyc + 1;
    step();
    rx_end = 0; rx_fcs_ok = 0; rx_dur = '0;
  endtask

  task automatic pulse_tx(input bit ucast, output int e);
    step();
    tx_done = 1; tx_unicast = ucast; e = cyc + 1;
    step();
    tx_done = 0; tx_unicast = 0;
  endtask

  task automatic pulse_bo(input int slots, output int e);
    step();
    bo_start = 1; bo_slots = 10'(slots); e = cyc + 1;
    step();
    bo_start = 0;
  endtask

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    summary();
  end

  initial begin
    int e, e2;
    repeat (3) step();
    chk({medium_busy, tx_resp_start, tx_release, resp_missed, timeout_evt, resp_rcvd} == 6'b0,
        "R10 reset outputs", {medium_busy, tx_resp_start, tx_release, resp_missed, timeout_evt, resp_rcvd}, 0);
    rst_n = 1;
    repeat (2) step();

    // R2: NAV load, smaller value ignored, larger value taken
    pulse_rx(6, 1, e);
    wait_until(e + 1); chk(medium_busy == 1, "R2 nav busy", medium_busy, 1);
    pulse_rx(2, 1, e2);
    wait_until(e + 5); chk(medium_busy == 1, "R2 smaller dur ignored", medium_busy, 1);
    wait_until(e + 6); chk(medium_busy == 0, "R2 nav expiry", medium_busy, 0);
    pulse_rx(9, 1, e);
    wait_until(e + 8); chk(medium_busy == 1, "R2 larger dur loaded", medium_busy, 1);
    wait_until(e + 9); chk(medium_busy == 0, "R2 larger dur expiry", medium_busy, 0);

    // R3: physical carrier sense
    step(); phy_cs = 1; #1; chk(medium_busy == 1, "R3 phy_cs busy", medium_busy, 1);
    step(); phy_cs = 0; #1; chk(medium_busy == 0, "R3 phy_cs idle", medium_busy, 0);

    // R11: bad FCS touches nothing
    resp_en = 1; resp_ready = 1;
    pulse_rx(8, 0, e);
    wait_until(e + 1); chk(medium_busy == 0, "R11 bad fcs no nav", medium_busy, 0);
    wait_until(e + 6);
    pulse_tx(1, e);
    expect_ev(e + TMO, 0, 3, "R11 timeout survives bad rx");
    pulse_rx(0, 0, e2);
    wait_until(e + TMO + 2);

    // R6: reply after SIFS
    pulse_rx(0, 1, e);
    expect_ev(e + SIFS, 0, 0, "R6 reply start");
    wait_until(e + SIFS + 2);
    // R6: ready raised before expiry
    resp_ready = 0;
    pulse_rx(0, 1, e);
    expect_ev(e + SIFS, 0, 0, "R6 late ready");
    resp_ready = 1;
    wait_until(e + SIFS + 2);
    // R7: not ready at expiry
    resp_ready = 0;
    pulse_rx(0, 1, e);
    expect_ev(e + SIFS, 0, 1, "R7 missed reply");
    wait_until(e + SIFS + 2);
    resp_en = 0;

    // R4: DIFS then slots
    pulse_bo(2, e);
    expect_ev(e + DIFS + 2*SLOT, 0, 2, "R4 release two slots");
    wait_until(e + DIFS + 2*SLOT + 2);
    pulse_bo(0, e);
    expect_ev(e + DIFS, 0, 2, "R4 release zero slots");
    wait_until(e + DIFS + 2);

    // R5: freeze by phy_cs mid-slot, last busy edge e+12, two slots left
    pulse_bo(3, e);
    expect_ev(e + 12 + DIFS + 2*SLOT, 0, 2, "R5 freeze phy_cs");
    wait_until(e + 10); phy_cs = 1;
    step(); step(); phy_cs = 0;
    wait_until(e + 12 + DIFS + 2*SLOT + 2);
    // R5: NAV load during DIFS, busy edges e+3..e+6
    pulse_bo(1, e);
    pulse_rx(4, 1, e2);
    expect_ev(e + 6 + DIFS + SLOT, 0, 2, "R5 freeze nav in difs");
    wait_until(e + 6 + DIFS + SLOT + 2);

    // R8: timeout
    pulse_tx(1, e);
    expect_ev(e + TMO, 0, 3, "R8 timeout");
    wait_until(e + TMO + 2);
    pulse_tx(0, e);
    wait_until(e + TMO + 2);

    // R9: cancel early, then on the expiry edge itself
    pulse_tx(1, e);
    wait_until(e + 3);
    pulse_rx(0, 1, e2);
    expect_ev(e2, 0, 4, "R9 cancel early");
    wait_until(e + TMO + 3);
    pulse_tx(1, e);
    wait_until(e + TMO - 2);
    pulse_rx(0, 1, e2);
    chk(e2 == e + TMO, "R9 collision setup", e2, e + TMO);
    expect_ev(e2, 0, 4, "R9 cancel on expiry edge");
    wait_until(e + TMO + 4);

    // R1: divider of 4, timeout 3 us
    cfg_cyc_per_us = 8'd4; cfg_timeout_us = 16'd3;
    step();
    pulse_tx(1, e);
    expect_ev(e + 12, 3, 3, "R1 divided timeout");
    wait_until(e + 16);

    chk(sb.size() == 0, "R8 scoreboard drained", sb.size(), 0);
    summary();
  end
endmodule